// File: doc/BRIEF.md
# Keyboard Data Strobe Latch

This block sits between a keyboard scanner and the CPU's I/O decode. When the scanner reports a new key, the block stores the 7-bit code with a "new key" strobe flag in bit 7. It also keeps an any-key-down status that follows a key-held level from the scanner. The CPU uses a 32-byte window at the top of the I/O space. The lower sixteen addresses return the stored byte. The seventeenth address, read once, acknowledges the key and reports whether a key is still held. A write to any of the upper sixteen addresses also acknowledges the key.

Acknowledging a key clears only the strobe flag; the code bits are kept. Read data comes back registered: it is valid on the cycle after the read strobe, with `rd_valid` marking it. Keyboard matrix scanning, auto-repeat and modifier decoding are done by other blocks.

Top module: `kbd_latch_top`

## Requirements
- R1: A cycle with `key_valid` high loads the latch with `{1'b1, key_code}`. The new value is returned by any later data read.
- R2: The any-key-down status is a register loaded each cycle with `key_valid | key_held`. It resets to 0.
- R3: A read (`cpu_rd`) of any address from IO_BASE+0x00 to IO_BASE+0x0F returns the whole latch byte, strobe bit 7 included, on `rd_data` with `rd_valid` high in the next cycle. The read leaves the latch unchanged.
- R4: A read of IO_BASE+0x10 returns 0x80 in the next cycle when the any-key-down status was set at the read edge, and 0x00 otherwise. It clears latch bit 7.
- R5: A write (`cpu_wr`) to any address from IO_BASE+0x10 to IO_BASE+0x1F clears latch bit 7 and keeps bits 6:0. It raises no `rd_valid` and has no other effect.
- R6: After reset the latch holds 0x00, the any-key-down status is 0 and `rd_valid` is 0.
- R7: When `key_valid` falls in the same cycle as a strobe clear (a read or a write), the new key wins and bit 7 ends up set with the new code.
- R8: Reads of IO_BASE+0x11 to IO_BASE+0x1F, and reads or writes outside the 32-byte window, give `rd_valid` low and leave the latch unchanged. Writes to IO_BASE+0x00 to IO_BASE+0x0F also leave the latch unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_valid | input | 1 | One-cycle pulse: new key code present |
| key_code | input | 7 | Code of the new key |
| key_held | input | 1 | Level: some key is held down |
| cpu_addr | input | 16 | CPU address |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wr | input | 1 | CPU write strobe |
| rd_data | output | 8 | Read data, valid one cycle after the read |
| rd_valid | output | 1 | High when rd_data carries a response for this window |

## Verification
A key arrival and a strobe clear can occur on the same clock edge. The bench creates this by raising `key_valid` in the same cycle as a read of the clear address, and again in the same cycle as a write to the clear range. After each collision it reads the data address and expects the new code with bit 7 set. For the read collision it also checks that the returned status reflects the any-key-down state from before that edge.

// File: rtl/kbd_pkg.sv
package kbd_pkg;
  localparam int CODE_W = 7;
  localparam int BYTE_W = CODE_W + 1;

  typedef struct packed {
    logic data_rd;   // read in data mirror range
    logic stat_rd;   // read of the status/clear address
    logic clr_wr;    // write in clear range
  } kbd_access_t;
endpackage

// File: rtl/kbd_addr_decode.sv
module kbd_addr_decode #(
  parameter int          ADDR_W  = 16,
  parameter logic [15:0] IO_BASE = 16'hC000,
  parameter int          MIR_W   = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  output kbd_pkg::kbd_access_t acc
);
  localparam int WIN_LSB = MIR_W + 1;

  logic in_window;
  logic upper_half;
  logic at_status;

  always_comb begin
    in_window  = (addr[ADDR_W-1:WIN_LSB] == IO_BASE[ADDR_W-1:WIN_LSB]);
    upper_half = addr[MIR_W];
    at_status  = (addr[MIR_W-1:0] == '0);
    acc.data_rd = rd & in_window & ~upper_half;
    acc.stat_rd = rd & in_window & upper_half & at_status;
    acc.clr_wr  = wr & in_window & upper_half;
  end
endmodule

// File: rtl/kbd_latch_core.sv
module kbd_latch_core
  import kbd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_valid,
  input  logic [CODE_W-1:0] key_code,
  input  logic              key_held,
  input  logic              clr_strobe,
  output logic [BYTE_W-1:0] latch_q,
  output logic              down_q
);
  logic [BYTE_W-1:0] latch_d;
  logic              latch_en;
  logic              down_d;

  always_comb begin
    latch_en = key_valid | clr_strobe;
    latch_d  = latch_q;
    if (key_valid)
      latch_d = {1'b1, key_code};
    else if (clr_strobe)
      latch_d = {1'b0, latch_q[CODE_W-1:0]};
    down_d = key_valid | key_held;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
      down_q  <= 1'b0;
    end else begin
      if (latch_en) latch_q <= latch_d;
      down_q <= down_d;
    end
  end

  // R1 / R7: a key always loads code and strobe, even against a clear
  a_r1_key_load: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid |=> (latch_q == {1'b1, $past(key_code)}));
  // R5: clear without a key drops bit 7 and keeps the code
  a_r5_clear_keeps_code: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_strobe && !key_valid) |=> (!latch_q[BYTE_W-1] && latch_q[CODE_W-1:0] == $past(latch_q[CODE_W-1:0])));
  // R3 / R8: no key and no clear leaves the latch alone
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_strobe && !key_valid) |=> $stable(latch_q));
  // R2: a key pulse always shows as held next cycle
  a_r2_down_on_key: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid |=> down_q);
endmodule

// File: rtl/kbd_rd_mux.sv
module kbd_rd_mux
  import kbd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  kbd_access_t       acc,
  input  logic [BYTE_W-1:0] latch_q,
  input  logic              down_q,
  output logic [BYTE_W-1:0] rd_data,
  output logic              rd_valid
);
  logic [BYTE_W-1:0] data_d;
  logic              valid_d;
  logic              data_en;

  always_comb begin
    valid_d = acc.data_rd | acc.stat_rd;
    data_en = valid_d;
    data_d  = acc.data_rd ? latch_q : {down_q, {CODE_W{1'b0}}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= valid_d;
      if (data_en) rd_data <= data_d;
    end
  end

  // R4: status reads carry only bit 7
  a_r4_status_shape: assert property (@(posedge clk) disable iff (!rst_n)
    acc.stat_rd |=> (rd_valid && rd_data[CODE_W-1:0] == '0));
  // R8: a cycle with no decoded read yields no response
  a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc.data_rd || acc.stat_rd) |=> !rd_valid);
endmodule

// File: rtl/kbd_latch_top.sv
module kbd_latch_top #(
  parameter int          ADDR_W  = 16,
  parameter logic [15:0] IO_BASE = 16'hC000,
  parameter int          MIRRORS = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        key_valid,
  input  logic [6:0]  key_code,
  input  logic        key_held,
  input  logic [15:0] cpu_addr,
  input  logic        cpu_rd,
  input  logic        cpu_wr,
  output logic [7:0]  rd_data,
  output logic        rd_valid
);
  import kbd_pkg::*;
  localparam int MIR_W = $clog2(MIRRORS);

  kbd_access_t       acc;
  logic [BYTE_W-1:0] latch_q;
  logic              down_q;
  logic              clr_strobe;

  kbd_addr_decode #(.ADDR_W(ADDR_W), .IO_BASE(IO_BASE), .MIR_W(MIR_W)) u_dec (
    .addr(cpu_addr[ADDR_W-1:0]), .rd(cpu_rd), .wr(cpu_wr), .acc(acc));

  always_comb clr_strobe = acc.stat_rd | acc.clr_wr;

  kbd_latch_core u_core (
    .clk(clk), .rst_n(rst_n), .key_valid(key_valid), .key_code(key_code),
    .key_held(key_held), .clr_strobe(clr_strobe), .latch_q(latch_q), .down_q(down_q));

  kbd_rd_mux u_mux (
    .clk(clk), .rst_n(rst_n), .acc(acc), .latch_q(latch_q), .down_q(down_q),
    .rd_data(rd_data), .rd_valid(rd_valid));

  // R3: a response only follows a CPU read
  a_r3_valid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(cpu_rd));
endmodule

// File: tb/sim_kbd_latch_top.sv
module sim_kbd_latch_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic key_valid = 1'b0;
  logic [6:0] key_code = '0;
  logic key_held = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic cpu_rd = 1'b0;
  logic cpu_wr = 1'b0;
  logic [7:0] rd_data;
  logic rd_valid;

  int checks = 0;
  int failures = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];
  logic [7:0] m_lat;   // bench model of the latch
  bit done = 0;

  always #2.5 clk = ~clk;

  kbd_latch_top u0 (.*);

  // monitor: pops the scoreboard whenever a response appears
  always @(posedge clk) begin
    #1;
    if (rst_n && rd_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        failures++;
        $display("FAIL unexpected response actual=%02h expected=none", rd_data);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rd_data !== e) begin
          failures++;
          $display("FAIL %s actual=%02h expected=%02h", t, rd_data, e);
        end
      end
    end
  end

  task automatic rd(input logic [15:0] a, input logic [7:0] e, input string t);
    @(negedge clk);
    cpu_addr = a; cpu_rd = 1'b1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    cpu_rd = 1'b0;
  endtask

  task automatic rd_none(input logic [15:0] a, input string t);
    @(negedge clk);
    cpu_addr = a; cpu_rd = 1'b1;
    @(posedge clk); #2;
    checks++;
    if (rd_valid !== 1'b0) begin
      failures++;
      $display("FAIL %s actual=%0b expected=0", t, rd_valid);
    end
    @(negedge clk);
    cpu_rd = 1'b0;
  endtask

  task automatic wr(input logic [15:0] a);
    @(negedge clk);
    cpu_addr = a; cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic press(input logic [6:0] c);
    @(negedge clk);
    key_valid = 1'b1; key_code = c;
    @(negedge clk);
    key_valid = 1'b0;
    m_lat = {1'b1, c};
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_lat = 8'h00;
    // R6: reset state
    #1;
    checks++;
    if (rd_valid !== 1'b0) begin failures++; $display("FAIL R6 actual=%0b expected=0", rd_valid); end
    rd(16'hC000, 8'h00, "R6 latch after reset");
    rd(16'hC010, 8'h00, "R6 down after reset");

    // R1 / R3: key load, mirrored reads, no change on read
    key_held = 1'b1;
    press(7'h41);
    rd(16'hC000, 8'hC1, "R1 load");
    rd(16'hC007, 8'hC1, "R3 mirror 7");
    rd(16'hC00F, 8'hC1, "R3 mirror F");

    // R4: status read with key held, then clear keeps code
    rd(16'hC010, 8'h80, "R4 held status");
    rd(16'hC003, 8'h41, "R4 bit7 cleared code kept");

    // R2: release key, status drops
    key_held = 1'b0;
    idle(2);
    rd(16'hC010, 8'h00, "R2 released status");

    // R5: write clear across range, code kept, no response
    press(7'h5A);
    rd(16'hC000, 8'hDA, "R1 second key");
    wr(16'hC01F);
    rd(16'hC000, 8'h5A, "R5 write clear C01F");
    press(7'h12);
    wr(16'hC013);
    rd(16'hC00A, 8'h12, "R5 write clear C013");
    press(7'h33);
    wr(16'hC010);
    rd_none(16'hC0FF, "R8 read outside window");
    rd(16'hC000, 8'h33, "R5 write clear C010");

    // R8: ignored accesses
    press(7'h2C);
    rd_none(16'hC011, "R8 read C011");
    rd_none(16'hC01F, "R8 read C01F");
    rd_none(16'hC020, "R8 read C020");
    wr(16'hC000);
    wr(16'hC00F);
    wr(16'hC020);
    wr(16'h4010);
    rd(16'hC000, 8'hAC, "R8 latch untouched");

    // R7: key and read-clear collide; status reflects prior state (released)
    idle(2);
    @(negedge clk);
    key_valid = 1'b1; key_code = 7'h66;
    cpu_addr = 16'hC010; cpu_rd = 1'b1;
    exp_q.push_back(8'h00); tag_q.push_back("R7 status at collision");
    @(negedge clk);
    key_valid = 1'b0; cpu_rd = 1'b0;
    rd(16'hC000, 8'hE6, "R7 key wins over read clear");

    // R7: key and write-clear collide
    @(negedge clk);
    key_valid = 1'b1; key_code = 7'h09;
    cpu_addr = 16'hC015; cpu_wr = 1'b1;
    @(negedge clk);
    key_valid = 1'b0; cpu_wr = 1'b0;
    rd(16'hC004, 8'h89, "R7 key wins over write clear");

    // R2: pulse alone without held level shows down for one cycle
    @(negedge clk);
    key_valid = 1'b1; key_code = 7'h01;
    @(negedge clk);
    key_valid = 1'b0;
    cpu_addr = 16'hC010; cpu_rd = 1'b1;
    exp_q.push_back(8'h80); tag_q.push_back("R2 down from key pulse");
    @(negedge clk);
    cpu_rd = 1'b0;
    rd(16'hC010, 8'h00, "R2 down falls without held");

    idle(3);
    checks++;
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL R3 missing responses actual=%0d expected=0", exp_q.size());
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule